// File: doc/BRIEF.md
# Configurable Serial Transceiver with Multiprocessor Framing

This block is a full-duplex asynchronous serial transmitter and receiver. One control word sets the frame shape: parity on or off, odd or even parity, one or two stop bits, 7 or 8 data bits, and plain or multiprocessor operation. In multiprocessor mode every frame carries one extra flag bit after the data. The flag tells an address frame from a data frame. The transmitter takes the flag from the control word, and the receiver returns it next to the received byte.

Both directions are paced by a `baud_tick` strobe at sixteen times the bit rate (the `OVS` parameter). Software writes the control word and transmit bytes through plain write strobes. It reads back the legalized control word, the received byte and its flag, a data-ready flag and three sticky error flags. The flags report a bad stop bit, a lost frame and a parity mismatch. A write with the keep-errors bit at 0 clears all three flags at once. Clearing receive-enable stops new receptions, but a frame that has already started is still completed and stored.

Top module: `sercom_uart`

## Requirements
- R1: The idle line is high. A frame is a start bit of 0, the data bits least significant first, then the extra bit if present, then the stop bits at 1. Each bit lasts `OVS` ticks.
- R2: With `stop2` (control bit 2) set the transmitter sends two stop bits, otherwise one. `tx_busy` stays high until the last stop bit ends.
- R3: With `par_en` (bit 0) set, a parity bit follows the data. With `par_odd` (bit 1) at 0 the parity bit makes the count of ones in data plus parity even; at 1 it makes it odd. A received mismatch sets `err_parity`.
- R4: With `len8` (bit 3) at 0 only data bits 0..6 are sent. A received 7-bit frame reads back with `rx_data[7]` at 0.
- R5: With `mp` (bit 4) set, the extra bit is `tx_adr` (bit 5) on transmit and is reported on `rx_adr` on receive. Parity is forced off and the length is forced to 8 bits, and `ctl_rdata` shows the forced values. `rx_adr` is 0 outside this mode.
- R6: A falling edge starts reception only if the line is still low at the middle of the start bit. A shorter low pulse is ignored and reception stays correct afterwards.
- R7: `err_frame` is set when the first stop bit is sampled low. Only the first stop bit is checked, so a frame with one stop bit is accepted even with `stop2` set.
- R8: When a frame completes while `rx_ready` is still 1 (and not being acknowledged), `err_over` is set, the older byte is kept and the new one is discarded.
- R9: A control write with `keep_err_n` (bit 7) at 0 clears `err_frame`, `err_over` and `err_parity` together. A write with that bit at 1 leaves them unchanged. Bit 7 always reads back as 1.
- R10: With `rx_en` (bit 6) at 0 no new frame is started. A frame already started when `rx_en` falls is still completed and stored.
- R11: `rx_ready` rises when a frame is stored and falls after a one-cycle `rx_ack`.
- R12: After reset `txd` is 1, `tx_busy`, `rx_ready` and all error flags are 0, and `ctl_rdata` is 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at OVS times the bit rate |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: [0] par_en, [1] par_odd, [2] stop2, [3] len8, [4] mp, [5] tx_adr, [6] rx_en, [7] keep_err_n |
| ctl_rdata | output | 8 | Legalized control word |
| tx_we | input | 1 | Transmit byte write strobe, accepted when not busy |
| tx_wdata | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmitter is sending a frame |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 8 | Last stored received byte |
| rx_adr | output | 1 | Address/data flag of the stored frame |
| rx_ready | output | 1 | Unread received byte present |
| rx_ack | input | 1 | Read acknowledge, clears rx_ready |
| err_frame | output | 1 | Sticky framing error |
| err_over | output | 1 | Sticky overrun error |
| err_parity | output | 1 | Sticky parity error |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe, that `tx_we` comes only while `tx_busy` is low, and that `rx_ack` is a one-cycle pulse. They also assume that the control word changes only between frames, except for `rx_en`. The stimulus meets these assumptions. Ticks come every second clock. Bytes are written only after the previous frame has been seen on the line. Acknowledges are single pulses. The only mid-frame control write is the one that lowers `rx_en`. Random frame settings and bytes from a fixed seed run in loopback, and directed frames driven onto the receive line cover the error, start-rejection and disable cases.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  localparam int DW        = 8;
  localparam int FRAME_MAX = 12;
  localparam int RXB_MAX   = 10;

  typedef struct packed {
    logic keep_err_n;
    logic rx_en;
    logic tx_adr;
    logic mp;
    logic len8;
    logic stop2;
    logic par_odd;
    logic par_en;
  } ctl_t;

  localparam ctl_t CTL_RST = '{keep_err_n: 1'b1, default: 1'b0};

  function automatic ctl_t legalize(ctl_t c);
    ctl_t r;
    r = c;
    r.keep_err_n = 1'b1;
    if (c.mp) begin
      r.par_en = 1'b0;
      r.len8   = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [3:0] dlen(ctl_t c);
    return c.len8 ? 4'd8 : 4'd7;
  endfunction

  function automatic logic has_extra(ctl_t c);
    return c.par_en | c.mp;
  endfunction

  function automatic logic par_bit(logic [DW-1:0] d, logic len8, logic odd);
    logic x;
    x = ^(len8 ? d : {1'b0, d[DW-2:0]});
    return x ^ odd;
  endfunction

  function automatic logic [3:0] rx_bits(ctl_t c);
    return dlen(c) + {3'b000, has_extra(c)} + 4'd1;
  endfunction

  function automatic logic [3:0] tx_bits(ctl_t c);
    return 4'd1 + dlen(c) + {3'b000, has_extra(c)} + (c.stop2 ? 4'd2 : 4'd1);
  endfunction

  function automatic logic [FRAME_MAX-1:0] tx_frame(ctl_t c, logic [DW-1:0] d);
    logic [FRAME_MAX-1:0] f;
    logic [3:0] n;
    f    = '1;
    f[0] = 1'b0;
    n    = dlen(c);
    for (int i = 0; i < DW; i++) begin
      if (i < int'(n)) f[i+1] = d[i];
    end
    if (has_extra(c)) f[n+4'd1] = c.mp ? c.tx_adr : par_bit(d, c.len8, c.par_odd);
    return f;
  endfunction

endpackage

// File: rtl/sercom_ctl.sv
module sercom_ctl import sercom_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output ctl_t          cfg,
  output logic          err_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= CTL_RST;
    else if (we) cfg <= legalize(ctl_t'(wdata));
  end

  assign err_clr = we & ~wdata[DW-1];

  a_r5_legal_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mp |-> (cfg.len8 && !cfg.par_en));

  a_r9_keep_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we) |-> cfg.keep_err_n);

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx import sercom_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  ctl_t          cfg,
  input  logic          load,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy
);

  localparam int CW = $clog2(OVS);

  logic [FRAME_MAX-1:0] frm;
  logic [3:0]           left;
  logic [CW-1:0]        tcnt;
  logic                 bit_end;
  logic                 unused_cfg;

  assign unused_cfg = ^{cfg.rx_en, cfg.keep_err_n};
  assign bit_end    = busy & tick & (tcnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm  <= '1;
      left <= '0;
      tcnt <= '0;
      busy <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        frm  <= tx_frame(cfg, data);
        left <= tx_bits(cfg);
        tcnt <= '0;
        busy <= 1'b1;
      end
    end else if (tick) begin
      tcnt <= tcnt + 1'b1;
      if (bit_end) begin
        frm  <= {1'b1, frm[FRAME_MAX-1:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end
    end
  end

  assign txd = busy ? frm[0] : 1'b1;

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left != 4'd0 && left <= 4'(FRAME_MAX)));

  a_r2_last_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left == 4'd1) |-> txd);

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx import sercom_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  ctl_t          cfg,
  input  logic          rd_ack,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_adr,
  output logic          rx_ready,
  output logic          ferr,
  output logic          oerr,
  output logic          perr
);

  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  rx_st_t             st;
  logic [1:0]         sync;
  logic               rxs;
  logic [CW-1:0]      cnt;
  logic [3:0]         idx;
  logic [RXB_MAX-1:0] sh;
  ctl_t               snap;
  logic               done_q;

  logic               ovr_evt;
  logic               store;
  logic [3:0]         d_len;
  logic [DW-1:0]      r_data;
  logic               r_extra;
  logic               r_stop;
  logic               par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end
  assign rxs = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '1;
      snap   <= CTL_RST;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (cfg.rx_en && !rxs) begin
            st   <= RX_START;
            cnt  <= '0;
            snap <= cfg;
          end
          RX_START: if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            idx <= '0;
            st  <= rxs ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_BITS: if (cnt == CW'(OVS - 1)) begin
            cnt     <= '0;
            sh[idx] <= rxs;
            idx     <= idx + 4'd1;
            if (idx == rx_bits(snap) - 4'd1) begin
              st     <= RX_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign d_len   = dlen(snap);
  assign r_data  = snap.len8 ? sh[DW-1:0] : {1'b0, sh[DW-2:0]};
  assign r_extra = sh[d_len];
  assign r_stop  = sh[d_len + {3'b000, has_extra(snap)}];
  assign par_bad = snap.par_en & (r_extra != par_bit(sh[DW-1:0], snap.len8, snap.par_odd));
  assign ovr_evt = done_q & rx_ready & ~rd_ack;
  assign store   = done_q & ~ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_adr   <= 1'b0;
      rx_ready <= 1'b0;
      ferr     <= 1'b0;
      oerr     <= 1'b0;
      perr     <= 1'b0;
    end else begin
      if (rd_ack) rx_ready <= 1'b0;
      if (err_clr) begin
        ferr <= 1'b0;
        oerr <= 1'b0;
        perr <= 1'b0;
      end
      if (ovr_evt) oerr <= 1'b1;
      if (store) begin
        rx_ready <= 1'b1;
        rx_data  <= r_data;
        rx_adr   <= snap.mp & r_extra;
        if (!r_stop) ferr <= 1'b1;
        if (par_bad) perr <= 1'b1;
      end
    end
  end

  a_r8_keep_older: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ($stable(rx_data) && rx_ready && oerr));

  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !done_q) |=> (!ferr && !oerr && !perr));

  a_r11_ready_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(done_q));

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !done_q) |=> !rx_ready);

  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && !cfg.rx_en) |=> (st == RX_IDLE));

  a_r5_snap_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (st != RX_IDLE && snap.mp) |-> (snap.len8 && !snap.par_en));

  a_r4_seven_bit_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !snap.len8) |=> !rx_data[DW-1]);

endmodule

// File: rtl/sercom_uart.sv
module sercom_uart import sercom_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          tx_we,
  input  logic [7:0]    tx_wdata,
  output logic          tx_busy,
  output logic          txd,
  input  logic          rxd,
  output logic [7:0]    rx_data,
  output logic          rx_adr,
  output logic          rx_ready,
  input  logic          rx_ack,
  output logic          err_frame,
  output logic          err_over,
  output logic          err_parity
);

  ctl_t cfg;
  logic err_clr;
  logic tx_load;

  sercom_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .cfg     (cfg),
    .err_clr (err_clr)
  );

  assign ctl_rdata = cfg;
  assign tx_load   = tx_we & ~tx_busy;

  sercom_tx #(.OVS(OVS)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (baud_tick),
    .cfg  (cfg),
    .load (tx_load),
    .data (tx_wdata),
    .txd  (txd),
    .busy (tx_busy)
  );

  sercom_rx #(.OVS(OVS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .rxd     (rxd),
    .cfg     (cfg),
    .rd_ack  (rx_ack),
    .err_clr (err_clr),
    .rx_data (rx_data),
    .rx_adr  (rx_adr),
    .rx_ready(rx_ready),
    .ferr    (err_frame),
    .oerr    (err_over),
    .perr    (err_parity)
  );

  a_r12_tx_idle_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> txd);

endmodule

// File: tb/test_sercom_uart.sv
module test_sercom_uart;

  localparam int BP = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       tx_we = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic       tx_busy, txd;
  logic       rxd;
  logic [7:0] rx_data;
  logic       rx_adr, rx_ready;
  logic       rx_ack = 1'b0;
  logic       err_frame, err_over, err_parity;
  logic       loop_en = 1'b1;
  logic       rxd_drv = 1'b1;
  logic       tdiv = 1'b0;
  int         n_chk = 0;
  int         n_bad = 0;

  assign rxd = loop_en ? txd : rxd_drv;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv      <= ~tdiv;
    baud_tick <= tdiv;
  end

  sercom_uart i_sercom_uart (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_adr(rx_adr), .rx_ready(rx_ready),
    .rx_ack(rx_ack), .err_frame(err_frame), .err_over(err_over),
    .err_parity(err_parity)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit pe, input bit odd, input bit s2, input bit l8,
                                    input bit mp, input bit adr, input bit rxen);
    return {1'b1, rxen, adr, mp, l8, s2, odd, pe};
  endfunction

  // Expected line bits of a frame, restated from R1..R5.
  task automatic exp_frame(input logic [7:0] c, input logic [7:0] d,
                           output logic [11:0] b, output int n);
    bit mp, pe, l8;
    int nd, ones;
    mp = c[4]; pe = c[0] && !mp; l8 = c[3] || mp;
    nd = l8 ? 8 : 7;
    b = '1; n = 0; ones = 0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < nd; i++) begin
      b[n] = d[i]; n++;
      if (d[i]) ones++;
    end
    if (mp) begin b[n] = c[5]; n++; end
    else if (pe) begin b[n] = ((ones % 2) == 1) ^ c[1]; n++; end
    b[n] = 1'b1; n++;
    if (c[2]) begin b[n] = 1'b1; n++; end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic send_raw(input logic [11:0] b, input int n, input int last_len);
    loop_en = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rxd_drv = b[k];
      repeat (((k == n - 1) ? last_len : BP) - 1) @(negedge clk);
    end
    @(negedge clk); rxd_drv = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic tx_loop(input logic [7:0] c, input logic [7:0] d, input string tag);
    logic [11:0] b;
    int n, w, bad;
    logic busy_last;
    exp_frame(c, d, b, n);
    loop_en = 1'b1;
    wr_ctl(c);
    @(negedge clk); tx_we = 1'b1; tx_wdata = d;
    @(negedge clk); tx_we = 1'b0;
    w = 0;
    while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
    repeat (BP / 2) @(negedge clk);
    bad = 0; busy_last = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (txd !== b[k]) bad++;
      if (k == n - 1) busy_last = tx_busy;
      repeat (BP) @(negedge clk);
    end
    check({tag, " R1 R3 R4 R5 line bits wrong"}, bad, 0);
    check({tag, " R2 busy in last stop"}, busy_last, 1);
    check({tag, " R2 busy after frame"}, tx_busy, 0);
    check({tag, " R11 rx_ready after loopback"}, rx_ready, 1);
    check({tag, " R4 R5 rx_data"}, rx_data, (c[3] || c[4]) ? d : {1'b0, d[6:0]});
    check({tag, " R5 rx_adr"}, rx_adr, c[4] ? c[5] : 1'b0);
    check({tag, " R3 R7 R8 no errors"}, {err_frame, err_over, err_parity}, 0);
    ack();
    check({tag, " R11 ack clears ready"}, rx_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] b;
    logic [7:0]  c;
    int n;
    void'($urandom(32'h1234_5A5A));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 txd idle", txd, 1);
    check("R12 flags", {tx_busy, rx_ready, err_frame, err_over, err_parity}, 0);
    check("R12 ctl_rdata", ctl_rdata, 8'h80);

    // R5 legalization readback: mp with parity and 7-bit requested
    wr_ctl(8'h11);
    check("R5 forced parity off, 8 bits", ctl_rdata, 8'h98);
    check("R9 keep bit reads one", ctl_rdata[7], 1);

    // Directed loopback corners
    tx_loop(mk(0,0,0,1,0,0,1), 8'hA5, "8N1");
    tx_loop(mk(1,0,1,1,0,0,1), 8'h37, "8E2");
    tx_loop(mk(1,1,0,0,0,0,1), 8'hC1, "7O1");
    tx_loop(mk(0,0,1,0,0,0,1), 8'hFF, "7N2");
    tx_loop(mk(1,1,0,0,1,1,1), 8'h5C, "MP adr");
    tx_loop(mk(0,0,0,1,1,0,1), 8'h00, "MP data");

    // Constrained random loopback
    for (int it = 0; it < 24; it++) begin
      logic [31:0] r;
      r = $urandom;
      tx_loop(mk(r[0], r[1], r[2], r[3], r[4], r[5], 1'b1), 8'($urandom), "rand");
    end

    // R7 framing error: first stop low, then short recovery (also R6 false start)
    c = mk(0,0,0,1,0,0,1);
    wr_ctl(c);
    exp_frame(c, 8'h6B, b, n);
    b[n-1] = 1'b0;
    send_raw(b, n, 24);
    repeat (2 * BP) @(negedge clk);
    check("R7 err_frame set", err_frame, 1);
    check("R7 data kept", rx_data, 8'h6B);
    ack();
    check("R6 no false frame after low stop", rx_ready, 0);
    wr_ctl(c & 8'h7F);
    check("R9 clear frame error", err_frame, 0);

    // R3 parity error, even parity, flipped parity bit
    c = mk(1,0,0,1,0,0,1);
    wr_ctl(c);
    exp_frame(c, 8'h13, b, n);
    b[9] = ~b[9];
    send_raw(b, n, BP);
    check("R3 err_parity set", err_parity, 1);
    check("R3 data stored", {rx_ready, rx_data}, {1'b1, 8'h13});
    ack();
    wr_ctl(c & 8'h7F);
    check("R9 clear parity error", err_parity, 0);

    // R8 overrun, then R9 write-1 leaves flags and write-0 clears
    c = mk(0,0,0,1,0,0,1);
    wr_ctl(c);
    exp_frame(c, 8'h21, b, n);
    send_raw(b, n, BP);
    exp_frame(c, 8'h9E, b, n);
    send_raw(b, n, BP);
    check("R8 err_over set", err_over, 1);
    check("R8 older byte kept", rx_data, 8'h21);
    check("R8 ready still set", rx_ready, 1);
    wr_ctl(c);
    check("R9 write one keeps err_over", err_over, 1);
    wr_ctl(c & 8'h7F);
    check("R9 write zero clears all", {err_frame, err_over, err_parity}, 0);
    ack();

    // R6 short start glitch ignored, then a good frame
    loop_en = 1'b0;
    @(negedge clk); rxd_drv = 1'b0;
    repeat (6) @(negedge clk); rxd_drv = 1'b1;
    repeat (2 * BP) @(negedge clk);
    check("R6 glitch ignored", rx_ready, 0);
    exp_frame(c, 8'h4D, b, n);
    send_raw(b, n, BP);
    check("R6 good frame after glitch", {rx_ready, rx_data}, {1'b1, 8'h4D});
    ack();

    // R7 only first stop checked: stop2 set, back-to-back one-stop frames
    c = mk(0,0,1,1,0,0,1);
    wr_ctl(c);
    fork
      begin
        exp_frame(c, 8'h81, b, n);
        send_raw(b, n - 1, BP);
        exp_frame(c, 8'h7E, b, n);
        send_raw(b, n - 1, BP);
      end
      begin
        while (rx_ready !== 1'b1) @(negedge clk);
        check("R7 first of back-to-back", rx_data, 8'h81);
        ack();
      end
    join
    check("R7 second of back-to-back", {rx_ready, rx_data}, {1'b1, 8'h7E});
    check("R7 single stop accepted", {err_frame, err_over}, 0);
    ack();

    // R10 disable mid-frame completes; disabled line starts nothing
    c = mk(0,0,0,1,1,0,1);
    wr_ctl(c);
    exp_frame(mk(0,0,0,1,1,1,1), 8'hB2, b, n);
    fork
      send_raw(b, n, BP);
      begin
        repeat (3 * BP) @(negedge clk);
        wr_ctl(c & 8'hBF);
      end
    join
    check("R10 frame in progress completed", {rx_ready, rx_data}, {1'b1, 8'hB2});
    check("R5 raw address flag", rx_adr, 1);
    ack();
    exp_frame(c, 8'h44, b, n);
    send_raw(b, n, BP);
    check("R10 disabled receives nothing", rx_ready, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule